// File: doc/BRIEF.md
# ADC Result Register Interlock Formatter

This block keeps the most recent 10-bit result delivered by an analog-to-digital converter. It presents that result to a processor bus as two 8-bit readable bytes, a high byte and a low byte. A mode input selects how the result bits are laid out across the two bytes. Two modes are left-justified: one plain and one signed, where the signed mode inverts the top result bit to turn offset-binary into two's complement. The third mode is an 8-bit truncation that places the eight most significant bits in the low byte.

The result is stored raw and is formatted when it is read, so a mode change shows at the read port straight away. In the left-justified modes a read of the high byte arms an interlock. The stored result then stays frozen, and any conversion that completes is thrown away until the low byte has been read. Software that reads high then low therefore always gets two halves of the same conversion. The truncation modes have no interlock at all.

Top module: `adc_result_regs`

## Requirements
- R1: In mode 00 (left-justified), the high byte (read address 0) returns result bits 9..2, with bit 9 in byte bit 7.
- R2: In modes 00 and 01, the low byte (read address 1) returns result bit 1 in byte bit 7 and result bit 0 in byte bit 6. Byte bits 5..0 read as zero.
- R3: In mode 01 (signed), the high byte is the mode 00 high byte with byte bit 7 inverted. All other bits match mode 00.
- R4: In modes 10 and 11 (truncation), the low byte returns result bits 9..2 and the high byte reads as zero.
- R5: When no interlock is pending, a conversion-complete strobe stores its value at that clock edge.
- R6: In modes 00 and 01, a high-byte read strobe arms the interlock. A conversion completing in the same cycle as that read is discarded, and so is every conversion while the interlock is armed. The low byte keeps its contents.
- R7: A low-byte read strobe releases the interlock at its clock edge. A conversion strobe in that same cycle is discarded. If the strobe is still asserted in the next cycle, it is stored then.
- R8: In modes 10 and 11 no interlock exists: every conversion is stored, whatever reads came before it.
- R9: Any change of the mode input releases a pending interlock at the next clock edge. The new layout applies to read data at once.
- R10: Reset releases the interlock and leaves the stored result unchanged.
- R11: Read data is combinational. It reflects the byte selected by the read address, and a read without the strobe has no effect on the interlock.

Top module ports (the parameter defaults give RES_W=10, BYTE_W=8):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done_i | input | 1 | Conversion-complete strobe |
| conv_value_i | input | RES_W | Converted value, valid with the strobe |
| fmt_mode_i | input | 2 | Layout mode: 00 left, 01 signed left, 10/11 truncation |
| rd_i | input | 1 | One-cycle bus read strobe |
| rd_addr_i | input | 1 | Byte select: 0 high, 1 low |
| rd_data_o | output | BYTE_W | Formatted byte for the selected address |

## Verification
The assertions take for granted that the read strobe lasts one cycle. They also assume the read address, the mode and the conversion inputs are known and stable around each clock edge once reset is released. A single address bit means a high read and a low read can never share a cycle. The stimulus changes every input on the falling edge and pulses each read strobe for exactly one cycle. A conversion strobe is held over two cycles only in the case built to test acceptance right after a release.

// File: rtl/conv_result_pkg.sv
package conv_result_pkg;

    typedef enum logic [1:0] {
        MODE_LJ_U  = 2'b00,
        MODE_LJ_S  = 2'b01,
        MODE_TRUNC = 2'b10,
        MODE_RSVD  = 2'b11
    } fmt_mode_e;

    localparam logic ADDR_HIGH = 1'b0;
    localparam logic ADDR_LOW  = 1'b1;

endpackage

// File: rtl/conv_result_store.sv
module conv_result_store
    import conv_result_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [RES_W-1:0] value_i,
    input  logic [1:0]       mode_i,
    input  logic             rd_i,
    input  logic             addr_i,
    output logic [RES_W-1:0] raw_o
);

    typedef struct packed {
        logic [RES_W-1:0] raw;
        logic             lock;
        logic [1:0]       mode;
    } state_t;

    state_t st_d, st_q;
    logic   left_mode;
    logic   hi_rd;
    logic   lo_rd;
    logic   mode_chg;
    logic   accept;

    always_comb begin
        left_mode = ~mode_i[1];
        hi_rd     = rd_i && (addr_i == ADDR_HIGH);
        lo_rd     = rd_i && (addr_i == ADDR_LOW);
        mode_chg  = (mode_i != st_q.mode);
        accept    = done_i && !st_q.lock && !(left_mode && hi_rd);

        st_d      = st_q;
        st_d.mode = mode_i;
        if (accept) begin
            st_d.raw = value_i;
        end
        if (mode_chg || !left_mode) begin
            st_d.lock = 1'b0;
        end else if (lo_rd) begin
            st_d.lock = 1'b0;
        end else if (hi_rd) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lock <= 1'b0;
            st_q.mode <= MODE_LJ_U;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;

    // R6: an armed interlock keeps the stored result frozen
    p_lock_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable(st_q.raw));

    // R5: an unblocked strobe stores its value
    p_free_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !st_q.lock && !(hi_rd && !mode_i[1])) |=> (st_q.raw == $past(value_i)));

    // R7: a low-byte read releases the interlock
    p_low_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && st_q.lock) |=> !st_q.lock);

    // R8: no interlock ever arms in truncation modes
    p_trunc_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[1] |=> !st_q.lock);

    // R9: a mode change releases the interlock
    p_mode_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != st_q.mode) |=> !st_q.lock);

endmodule

// File: rtl/conv_result_format.sv
module conv_result_format
    import conv_result_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  raw_i,
    input  logic [1:0]        mode_i,
    input  logic              addr_i,
    output logic [BYTE_W-1:0] byte_o
);

    localparam int LOW_W = RES_W - BYTE_W;
    localparam int PAD_W = BYTE_W - LOW_W;

    logic [BYTE_W-1:0] top_bits;
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;

    always_comb begin
        top_bits = raw_i[RES_W-1:LOW_W];
        case (mode_i)
            MODE_LJ_U: begin
                hi_byte = top_bits;
                lo_byte = {raw_i[LOW_W-1:0], {PAD_W{1'b0}}};
            end
            MODE_LJ_S: begin
                hi_byte = {~top_bits[BYTE_W-1], top_bits[BYTE_W-2:0]};
                lo_byte = {raw_i[LOW_W-1:0], {PAD_W{1'b0}}};
            end
            default: begin
                hi_byte = '0;
                lo_byte = top_bits;
            end
        endcase
        byte_o = (addr_i == ADDR_HIGH) ? hi_byte : lo_byte;
    end

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import conv_result_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done_i,
    input  logic [RES_W-1:0]  conv_value_i,
    input  logic [1:0]        fmt_mode_i,
    input  logic              rd_i,
    input  logic              rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o
);

    logic [RES_W-1:0] raw_q;

    conv_result_store #(.RES_W(RES_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (conv_done_i),
        .value_i (conv_value_i),
        .mode_i  (fmt_mode_i),
        .rd_i    (rd_i),
        .addr_i  (rd_addr_i),
        .raw_o   (raw_q)
    );

    conv_result_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_format (
        .raw_i  (raw_q),
        .mode_i (fmt_mode_i),
        .addr_i (rd_addr_i),
        .byte_o (rd_data_o)
    );

    // R4: truncation modes never show data in the high byte
    p_trunc_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_mode_i[1] && rd_addr_i == ADDR_HIGH) |-> (rd_data_o == '0));

endmodule

// File: tb/adc_result_regs_test.sv
`timescale 1ns/1ps
module adc_result_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_value = '0;
    logic [1:0] mode = 2'b00;
    logic       rd = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_result_regs uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_done_i  (conv_done),
        .conv_value_i (conv_value),
        .fmt_mode_i   (mode),
        .rd_i         (rd),
        .rd_addr_i    (addr),
        .rd_data_o    (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic conv(input logic [9:0] v);
        conv_done = 1'b1;
        conv_value = v;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] got);
        rd = 1'b1;
        addr = a;
        #1 got = rd_data;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] got);
        addr = a;
        #1 got = rd_data;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m;
        @(negedge clk);
    endtask

    task automatic t_basic_load();
        logic [7:0] v;
        set_mode(2'b00);
        conv(10'h2A5);
        peek(1'b0, v); check("R1 R5 R11 high after load", v, 8'hA9);
        peek(1'b1, v); check("R2 low after load", v, 8'h40);
    endtask

    task automatic t_signed();
        logic [7:0] v;
        mode = 2'b01;
        peek(1'b0, v); check("R3 R9 signed high immediate", v, 8'h29);
        peek(1'b1, v); check("R2 signed low", v, 8'h40);
        @(negedge clk);
    endtask

    task automatic t_trunc();
        logic [7:0] v;
        set_mode(2'b10);
        peek(1'b1, v); check("R4 trunc low mode 10", v, 8'hA9);
        peek(1'b0, v); check("R4 trunc high mode 10", v, 8'h00);
        set_mode(2'b11);
        peek(1'b1, v); check("R4 trunc low mode 11", v, 8'hA9);
        peek(1'b0, v); check("R4 trunc high mode 11", v, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        set_mode(2'b00);
        conv(10'h3FF);
        bus_read(1'b0, v); check("R6 high read value", v, 8'hFF);
        conv(10'h000);
        peek(1'b1, v); check("R6 low frozen under lock", v, 8'hC0);
        peek(1'b0, v); check("R6 high kept under lock", v, 8'hFF);
        bus_read(1'b1, v); check("R6 low read returns coherent", v, 8'hC0);
        conv(10'h000);
        peek(1'b0, v); check("R7 load after release", v, 8'h00);
    endtask

    task automatic t_same_cycle_high();
        logic [7:0] v;
        rd = 1'b1; addr = 1'b0; conv_done = 1'b1; conv_value = 10'h155;
        #1 v = rd_data;
        check("R6 high read with strobe", v, 8'h00);
        @(negedge clk);
        rd = 1'b0; conv_done = 1'b0;
        bus_read(1'b1, v); check("R6 same-cycle result dropped", v, 8'h00);
        conv(10'h155);
        peek(1'b0, v); check("R5 high after unlock", v, 8'h55);
        peek(1'b1, v); check("R2 low after unlock", v, 8'h40);
    endtask

    task automatic t_release_cycle();
        logic [7:0] v;
        bus_read(1'b0, v);
        rd = 1'b1; addr = 1'b1; conv_done = 1'b1; conv_value = 10'h2A5;
        #1 v = rd_data;
        check("R7 low read at release", v, 8'h40);
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        conv_done = 1'b0;
        peek(1'b0, v); check("R7 held strobe accepted next cycle", v, 8'hA9);
        bus_read(1'b0, v);
        rd = 1'b1; addr = 1'b1; conv_done = 1'b1; conv_value = 10'h3FF;
        @(negedge clk);
        rd = 1'b0; conv_done = 1'b0;
        @(negedge clk);
        peek(1'b0, v); check("R7 release-cycle strobe dropped", v, 8'hA9);
    endtask

    task automatic t_trunc_nolock();
        logic [7:0] v;
        set_mode(2'b10);
        bus_read(1'b1, v);
        bus_read(1'b0, v); check("R4 high read trunc", v, 8'h00);
        conv(10'h155);
        peek(1'b1, v); check("R8 update after high read", v, 8'h55);
        bus_read(1'b0, v);
        conv(10'h3FF);
        peek(1'b1, v); check("R8 second update", v, 8'hFF);
    endtask

    task automatic t_mode_release();
        logic [7:0] v;
        set_mode(2'b00);
        conv(10'h0F0);
        bus_read(1'b0, v); check("R1 high before mode change", v, 8'h3C);
        mode = 2'b01;
        peek(1'b0, v); check("R9 signed layout at once", v, 8'hBC);
        @(negedge clk);
        conv(10'h155);
        peek(1'b0, v); check("R9 lock cleared by mode change", v, 8'hD5);
    endtask

    task automatic t_reset_keep();
        logic [7:0] v;
        set_mode(2'b00);
        bus_read(1'b0, v); check("R6 lock before reset", v, 8'h55);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(1'b0, v); check("R10 data kept over reset", v, 8'h55);
        conv(10'h3FF);
        peek(1'b0, v); check("R10 lock cleared by reset", v, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_basic_load();
        t_signed();
        t_trunc();
        t_lock();
        t_same_cycle_high();
        t_release_cycle();
        t_trunc_nolock();
        t_mode_release();
        t_reset_keep();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule